// File: doc/BRIEF.md
# Power Event Status and Wake Router

This block gathers power-management events from several sources into a bank of sticky status bits. The sources are PME requests from internal devices, an external PME pin, a ring-indicate pin, a battery-low pin, a USB controller wake request, and PCI Express PME and assert/deassert messages. Each status bit has a matching enable bit. Software reads both registers through a small synchronous port and clears status bits by writing ones to them.

The outputs depend on the current sleep state and on a routing control bit. From the enabled status bits the block drives a level-sensitive SCI or SMI interrupt and a single-cycle wake request. An S5 entry caused by power-button override or power failure suppresses all of these outputs. A status bit raised by a PCI Express assert message can only be cleared after the matching deassert message has arrived.

The sleep-state sequencer, address decoding wider than the two-register port, and the generation of PCI Express messages belong to neighbouring blocks.

Top module: `pwr_event_router`

## Requirements
- R1: After reset the status and enable registers read 0 and sciOut, smiOut and wakeOut are low.
- R2: Writing to the status register (regAddr 0) clears every status bit written as 1 and leaves bits written as 0 unchanged. byteEn[0] gates bits 7:0 and byteEn[1] gates bits 15:8. The status bit positions are: 0 internal PME, 1 external PME, 2 ring indicate, 3 battery low, 4 USB wake, 5 PCI Express. All other bits read 0.
- R3: A status bit is set in a cycle when one of its synchronous sources is high. Bit 0 sets on any intDevPme bit, bit 4 on usbWakeReq, and bit 5 on any rootPortPme bit or on pcieAssertMsg.
- R4: The pin inputs pass through a synchronizer. extPmeIn and ringIn set their bits on a rising edge only. batLowIn sets its bit for as long as it is high, so a clear does not hold while the pin stays high.
- R5: When a hardware set and a software clear hit the same status bit in the same cycle, the bit stays set.
- R6: The enable register (regAddr 1) uses the same bit positions as the status register. It reads back what was written on the implemented bits and reads 0 on all other bits. Writes are byte-gated as in R2.
- R7: While some status bit and its enable bit are both 1 and the system is not blocked (R8), sciOut is high when sciEn is 1 and smiOut is high when sciEn is 0. The output stays high until that condition ends, and sciOut and smiOut are never high together.
- R8: When sleepState is 5 (S5) and s5Override is 1, sciOut, smiOut and wakeOut all stay low.
- R9: wakeOut pulses high for one cycle when an enabled status bit changes from 0 to 1 while sleepState is 1 to 5 (S1 to S5) and the system is not blocked. A bit that is already set, or any set while sleepState is 0 (S0), causes no pulse.
- R10: If bit 5 was set by pcieAssertMsg, a write-1 clear has no effect until pcieDeassertMsg has been received. Once the bit is cleared, the next assert message makes the clear wait again.
- R11: resumeRst clears the USB wake status bit and leaves every other bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleepState | input | 3 | Current sleep state, 0 = S0 through 5 = S5 |
| s5Override | input | 1 | S5 was entered by power-button override or power failure |
| sciEn | input | 1 | 1 routes the interrupt to SCI, 0 routes it to SMI |
| extPmeIn | input | 1 | External PME pin, asynchronous, active high |
| ringIn | input | 1 | Ring-indicate pin, asynchronous, active high |
| batLowIn | input | 1 | Battery-low pin, asynchronous, active high |
| intDevPme | input | NUM_INT_DEV | PME requests from internal devices |
| usbWakeReq | input | 1 | USB controller wake request |
| rootPortPme | input | NUM_ROOT_PORTS | PME message received on a root port |
| pcieAssertMsg | input | 1 | PME assert message from the upstream link |
| pcieDeassertMsg | input | 1 | PME deassert message from the upstream link |
| resumeRst | input | 1 | Resume-well reset, clears the USB wake bit |
| regAddr | input | 1 | 0 selects status, 1 selects enable |
| rdEn | input | 1 | Read strobe; rdData is valid on the next cycle |
| wrEn | input | 1 | Write strobe |
| byteEn | input | 2 | Byte enables for the write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, registered |
| sciOut | output | 1 | Level-sensitive SCI request |
| smiOut | output | 1 | Level-sensitive SMI request |
| wakeOut | output | 1 | Single-cycle wake request |

## Verification
The in-RTL assertions are checked on every cycle. They confirm that SCI and SMI are never high together, that a wake pulse only follows a set of an enabled bit outside S0 and outside override S5, that a status bit only falls after a clear strobe or a resume reset, and that the PCI Express assert flag only rises after an assert message. Other behaviour can only be shown by the bench scenarios. These cover the byte-gated clears, edge versus level capture on the synchronized pins, hardware winning over a clear in the same cycle, the clear held back until a deassert message, and the exact count of wake pulses in each sleep state.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;
  localparam int REG_W = 16;

  localparam int BIT_INT_PME = 0;
  localparam int BIT_EXT_PME = 1;
  localparam int BIT_RING    = 2;
  localparam int BIT_BATLOW  = 3;
  localparam int BIT_USB     = 4;
  localparam int BIT_PCIE    = 5;

  localparam logic [REG_W-1:0] IMPL_MASK = 16'h003F;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;

  localparam logic [2:0] SLP_S0 = 3'd0;
  localparam logic [2:0] SLP_S1 = 3'd1;
  localparam logic [2:0] SLP_S5 = 3'd5;

  typedef struct packed {
    logic [REG_W-1:0] hwSet;
    logic [REG_W-1:0] swClr;
    logic [REG_W-1:0] enMask;
    logic [REG_W-1:0] enData;
    logic             resumeClr;
  } evtStrobe_t;
endpackage

// File: rtl/pwr_evt_ctrl.sv
module pwr_evt_ctrl
  import pwr_evt_pkg::*;
#(
  parameter int NUM_INT_DEV    = 4,
  parameter int NUM_ROOT_PORTS = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      extPmeIn,
  input  logic                      ringIn,
  input  logic                      batLowIn,
  input  logic [NUM_INT_DEV-1:0]    intDevPme,
  input  logic                      usbWakeReq,
  input  logic [NUM_ROOT_PORTS-1:0] rootPortPme,
  input  logic                      pcieAssertMsg,
  input  logic                      pcieDeassertMsg,
  input  logic                      resumeRst,
  input  logic                      regAddr,
  input  logic                      wrEn,
  input  logic [1:0]                byteEn,
  input  logic [REG_W-1:0]          wrData,
  output evtStrobe_t                strb
);
  localparam int NUM_PINS = 3;
  localparam int PIN_EXT  = 0;
  localparam int PIN_RING = 1;
  localparam int PIN_BAT  = 2;

  logic [NUM_PINS-1:0] pinVec;
  logic [NUM_PINS-1:0] syncVec;
  logic [NUM_PINS-1:0] prevVec;
  logic [NUM_PINS-1:0] riseVec;

  assign pinVec = {batLowIn, ringIn, extPmeIn};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] shf;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shf <= '0;
      else        shf <= {shf[SYNC_STAGES-2:0], pinVec[p]};
    end
    assign syncVec[p] = shf[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevVec <= '0;
    else        prevVec <= syncVec;
  end
  assign riseVec = syncVec & ~prevVec;

  logic setByAssert;
  logic deassertSeen;
  logic pcieClrOk;
  logic [REG_W-1:0] byteMask;
  logic statusWr;
  logic enableWr;

  assign byteMask  = {{8{byteEn[1]}}, {8{byteEn[0]}}};
  assign statusWr  = wrEn && (regAddr == ADDR_STATUS);
  assign enableWr  = wrEn && (regAddr == ADDR_ENABLE);
  assign pcieClrOk = !setByAssert || deassertSeen;

  always_comb begin
    strb = '0;
    strb.hwSet[BIT_INT_PME] = |intDevPme;
    strb.hwSet[BIT_EXT_PME] = riseVec[PIN_EXT];
    strb.hwSet[BIT_RING]    = riseVec[PIN_RING];
    strb.hwSet[BIT_BATLOW]  = syncVec[PIN_BAT];
    strb.hwSet[BIT_USB]     = usbWakeReq;
    strb.hwSet[BIT_PCIE]    = (|rootPortPme) || pcieAssertMsg;
    if (statusWr) begin
      strb.swClr = wrData & byteMask & IMPL_MASK;
      strb.swClr[BIT_PCIE] = wrData[BIT_PCIE] & byteMask[BIT_PCIE] & pcieClrOk;
    end
    if (enableWr) begin
      strb.enMask = byteMask & IMPL_MASK;
      strb.enData = wrData;
    end
    strb.resumeClr = resumeRst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setByAssert  <= 1'b0;
      deassertSeen <= 1'b0;
    end else if (pcieAssertMsg) begin
      setByAssert  <= 1'b1;
      deassertSeen <= 1'b0;
    end else begin
      if (strb.swClr[BIT_PCIE] && !strb.hwSet[BIT_PCIE]) begin
        setByAssert  <= 1'b0;
        deassertSeen <= 1'b0;
      end
      if (pcieDeassertMsg) deassertSeen <= 1'b1;
    end
  end

  // R10
  assert_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setByAssert) |-> $past(pcieAssertMsg));

endmodule

// File: rtl/pwr_evt_dp.sv
module pwr_evt_dp
  import pwr_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  evtStrobe_t       strb,
  input  logic [2:0]       sleepState,
  input  logic             s5Override,
  input  logic             sciEn,
  input  logic             regAddr,
  input  logic             rdEn,
  output logic [REG_W-1:0] rdData,
  output logic             sciOut,
  output logic             smiOut,
  output logic             wakeOut
);
  logic [REG_W-1:0] status;
  logic [REG_W-1:0] enable;
  logic [REG_W-1:0] usbMask;
  logic [REG_W-1:0] statusNxt;
  logic [REG_W-1:0] newlySet;
  logic pending;
  logic blocked;
  logic asleep;

  assign usbMask   = strb.resumeClr ? (REG_W'(1) << BIT_USB) : '0;
  assign statusNxt = ((status & ~strb.swClr & ~usbMask) | strb.hwSet) & IMPL_MASK;
  assign newlySet  = strb.hwSet & ~status & enable & IMPL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= statusNxt;
      enable <= ((enable & ~strb.enMask) | (strb.enData & strb.enMask)) & IMPL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdData <= '0;
    else if (rdEn) rdData <= (regAddr == ADDR_ENABLE) ? enable : status;
  end

  assign blocked = (sleepState == SLP_S5) && s5Override;
  assign asleep  = (sleepState >= SLP_S1) && (sleepState <= SLP_S5);
  assign pending = |(status & enable);
  assign sciOut  = pending && !blocked && sciEn;
  assign smiOut  = pending && !blocked && !sciEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wakeOut <= 1'b0;
    else        wakeOut <= (|newlySet) && asleep && !blocked;
  end

  // R7
  sci_smi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sciOut && smiOut));

  // R9
  wake_when_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wakeOut |-> ($past(sleepState) != SLP_S0) && !($past(sleepState) == SLP_S5 && $past(s5Override)));

  // R9
  wake_from_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wakeOut |-> ($past(strb.hwSet & enable) != '0));

  // R11
  resume_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strb.resumeClr && !strb.hwSet[BIT_USB]) |-> !status[BIT_USB]);

  for (genvar gi = 0; gi < REG_W; gi++) begin : g_fall
    // R2
    sticky_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[gi]) |-> $past(strb.swClr[gi] || (strb.resumeClr && (gi == BIT_USB))));
  end

endmodule

// File: rtl/pwr_event_router.sv
module pwr_event_router
  import pwr_evt_pkg::*;
#(
  parameter int NUM_INT_DEV    = 4,
  parameter int NUM_ROOT_PORTS = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                sleepState,
  input  logic                      s5Override,
  input  logic                      sciEn,
  input  logic                      extPmeIn,
  input  logic                      ringIn,
  input  logic                      batLowIn,
  input  logic [NUM_INT_DEV-1:0]    intDevPme,
  input  logic                      usbWakeReq,
  input  logic [NUM_ROOT_PORTS-1:0] rootPortPme,
  input  logic                      pcieAssertMsg,
  input  logic                      pcieDeassertMsg,
  input  logic                      resumeRst,
  input  logic                      regAddr,
  input  logic                      rdEn,
  input  logic                      wrEn,
  input  logic [1:0]                byteEn,
  input  logic [15:0]               wrData,
  output logic [15:0]               rdData,
  output logic                      sciOut,
  output logic                      smiOut,
  output logic                      wakeOut
);
  evtStrobe_t strb;

  pwr_evt_ctrl #(
    .NUM_INT_DEV   (NUM_INT_DEV),
    .NUM_ROOT_PORTS(NUM_ROOT_PORTS),
    .SYNC_STAGES   (SYNC_STAGES)
  ) ctrl_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .extPmeIn       (extPmeIn),
    .ringIn         (ringIn),
    .batLowIn       (batLowIn),
    .intDevPme      (intDevPme),
    .usbWakeReq     (usbWakeReq),
    .rootPortPme    (rootPortPme),
    .pcieAssertMsg  (pcieAssertMsg),
    .pcieDeassertMsg(pcieDeassertMsg),
    .resumeRst      (resumeRst),
    .regAddr        (regAddr),
    .wrEn           (wrEn),
    .byteEn         (byteEn),
    .wrData         (wrData),
    .strb           (strb)
  );

  pwr_evt_dp dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .sleepState(sleepState),
    .s5Override(s5Override),
    .sciEn     (sciEn),
    .regAddr   (regAddr),
    .rdEn      (rdEn),
    .rdData    (rdData),
    .sciOut    (sciOut),
    .smiOut    (smiOut),
    .wakeOut   (wakeOut)
  );
endmodule

// File: tb/pwr_event_router_tb.sv
module pwr_event_router_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sleepState = 3'd0;
  logic s5Override = 1'b0;
  logic sciEn = 1'b1;
  logic extPmeIn = 1'b0;
  logic ringIn = 1'b0;
  logic batLowIn = 1'b0;
  logic [3:0] intDevPme = '0;
  logic usbWakeReq = 1'b0;
  logic [3:0] rootPortPme = '0;
  logic pcieAssertMsg = 1'b0;
  logic pcieDeassertMsg = 1'b0;
  logic resumeRst = 1'b0;
  logic regAddr = 1'b0;
  logic rdEn = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] byteEn = 2'b00;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic sciOut, smiOut, wakeOut;

  int testsRun = 0;
  int testsFailed = 0;
  int wakeCnt = 0;

  always #5 clk = ~clk;

  pwr_event_router dut_i (
    .clk(clk), .rst_n(rst_n), .sleepState(sleepState), .s5Override(s5Override),
    .sciEn(sciEn), .extPmeIn(extPmeIn), .ringIn(ringIn), .batLowIn(batLowIn),
    .intDevPme(intDevPme), .usbWakeReq(usbWakeReq), .rootPortPme(rootPortPme),
    .pcieAssertMsg(pcieAssertMsg), .pcieDeassertMsg(pcieDeassertMsg),
    .resumeRst(resumeRst), .regAddr(regAddr), .rdEn(rdEn), .wrEn(wrEn),
    .byteEn(byteEn), .wrData(wrData), .rdData(rdData), .sciOut(sciOut),
    .smiOut(smiOut), .wakeOut(wakeOut)
  );

  always @(negedge clk) if (wakeOut === 1'b1) wakeCnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d; byteEn = be;
    @(negedge clk);
    wrEn = 1'b0; byteEn = 2'b00; wrData = '0;
  endtask

  task automatic rdReg(input logic a, output logic [15:0] v);
    @(negedge clk);
    rdEn = 1'b1; regAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseUsb();
    @(negedge clk); usbWakeReq = 1'b1;
    @(negedge clk); usbWakeReq = 1'b0;
  endtask

  task automatic testReset();
    logic [15:0] v;
    chk("R1 sci", sciOut, 0);
    chk("R1 smi", smiOut, 0);
    chk("R1 wake", wakeOut, 0);
    rdReg(1'b0, v); chk("R1 status", v, 16'h0000);
    rdReg(1'b1, v); chk("R1 enable", v, 16'h0000);
  endtask

  task automatic testSourcesAndClear();
    logic [15:0] v;
    @(negedge clk); intDevPme = 4'b0100;
    @(negedge clk); intDevPme = 4'b0000;
    rdReg(1'b0, v); chk("R3 internal pme", v, 16'h0001);
    wrReg(1'b0, 16'h0001, 2'b01);
    rdReg(1'b0, v); chk("R2 write-1 clear", v, 16'h0000);
    pulseUsb();
    wrReg(1'b0, 16'h0000, 2'b11);
    rdReg(1'b0, v); chk("R2 write-0 no effect", v, 16'h0010);
    wrReg(1'b0, 16'h0010, 2'b10);
    rdReg(1'b0, v); chk("R2 byte strobe gates low byte", v, 16'h0010);
    wrReg(1'b0, 16'h0010, 2'b01);
    rdReg(1'b0, v); chk("R2 low byte clear", v, 16'h0000);
    @(negedge clk); rootPortPme = 4'b0010;
    @(negedge clk); rootPortPme = 4'b0000;
    rdReg(1'b0, v); chk("R3 root port pme", v, 16'h0020);
    wrReg(1'b0, 16'h0020, 2'b01);
    rdReg(1'b0, v); chk("R10 port-set bit clears freely", v, 16'h0000);
  endtask

  task automatic testPins();
    logic [15:0] v;
    @(negedge clk); extPmeIn = 1'b1;
    waitCyc(5);
    rdReg(1'b0, v); chk("R4 external pme edge", v, 16'h0002);
    wrReg(1'b0, 16'h0002, 2'b01);
    waitCyc(3);
    rdReg(1'b0, v); chk("R4 held pin no re-set", v, 16'h0000);
    extPmeIn = 1'b0;
    @(negedge clk); ringIn = 1'b1;
    waitCyc(5);
    rdReg(1'b0, v); chk("R4 ring edge", v, 16'h0004);
    wrReg(1'b0, 16'h0004, 2'b01);
    ringIn = 1'b0;
    @(negedge clk); batLowIn = 1'b1;
    waitCyc(5);
    rdReg(1'b0, v); chk("R4 battery low level", v, 16'h0008);
    wrReg(1'b0, 16'h0008, 2'b01);
    rdReg(1'b0, v); chk("R4 battery low held re-sets", v, 16'h0008);
    batLowIn = 1'b0;
    waitCyc(5);
    wrReg(1'b0, 16'h0008, 2'b01);
    rdReg(1'b0, v); chk("R4 battery low clears after release", v, 16'h0000);
  endtask

  task automatic testEnable();
    logic [15:0] v;
    wrReg(1'b1, 16'hFFFF, 2'b11);
    rdReg(1'b1, v); chk("R6 enable readback", v, 16'h003F);
    wrReg(1'b1, 16'h0000, 2'b10);
    rdReg(1'b1, v); chk("R6 byte gated enable", v, 16'h003F);
    wrReg(1'b1, 16'h0000, 2'b11);
    rdReg(1'b1, v); chk("R6 enable cleared", v, 16'h0000);
  endtask

  task automatic testRouting();
    int w0;
    sleepState = 3'd0; sciEn = 1'b1;
    wrReg(1'b1, 16'h0010, 2'b01);
    w0 = wakeCnt;
    pulseUsb();
    @(negedge clk);
    chk("R7 sci in S0", {sciOut, smiOut}, 2'b10);
    chk("R9 no wake in S0", wakeCnt - w0, 0);
    sciEn = 1'b0;
    @(negedge clk);
    chk("R7 smi when routed", {sciOut, smiOut}, 2'b01);
    sciEn = 1'b1;
    waitCyc(3);
    chk("R7 level held", sciOut, 1);
    wrReg(1'b0, 16'h0010, 2'b01);
    chk("R7 drops after clear", {sciOut, smiOut}, 2'b00);
  endtask

  task automatic testWake();
    int w0;
    sleepState = 3'd3;
    w0 = wakeCnt;
    pulseUsb();
    @(negedge clk);
    chk("R9 one wake pulse in S3", wakeCnt - w0, 1);
    chk("R7 sci asleep", sciOut, 1);
    pulseUsb();
    @(negedge clk);
    chk("R9 already set no pulse", wakeCnt - w0, 1);
    wrReg(1'b0, 16'h0010, 2'b01);
    sleepState = 3'd5; s5Override = 1'b0;
    w0 = wakeCnt;
    pulseUsb();
    @(negedge clk);
    chk("R9 wake in software S5", wakeCnt - w0, 1);
    wrReg(1'b0, 16'h0010, 2'b01);
    s5Override = 1'b1;
    w0 = wakeCnt;
    pulseUsb();
    @(negedge clk);
    chk("R8 no wake in override S5", wakeCnt - w0, 0);
    chk("R8 no interrupt in override S5", {sciOut, smiOut}, 2'b00);
    s5Override = 1'b0;
    @(negedge clk);
    chk("R7 interrupt after override lifted", sciOut, 1);
    wrReg(1'b0, 16'h0010, 2'b01);
    sleepState = 3'd0;
  endtask

  task automatic testHwWins();
    logic [15:0] v;
    pulseUsb();
    @(negedge clk);
    usbWakeReq = 1'b1; wrEn = 1'b1; regAddr = 1'b0; wrData = 16'h0010; byteEn = 2'b01;
    @(negedge clk);
    usbWakeReq = 1'b0; wrEn = 1'b0; wrData = '0; byteEn = 2'b00;
    rdReg(1'b0, v); chk("R5 hardware set wins", v, 16'h0010);
    wrReg(1'b0, 16'h0010, 2'b01);
    rdReg(1'b0, v); chk("R5 later clear works", v, 16'h0000);
  endtask

  task automatic testPcie();
    logic [15:0] v;
    @(negedge clk); pcieAssertMsg = 1'b1;
    @(negedge clk); pcieAssertMsg = 1'b0;
    rdReg(1'b0, v); chk("R3 assert message sets", v, 16'h0020);
    wrReg(1'b0, 16'h0020, 2'b01);
    rdReg(1'b0, v); chk("R10 clear held without deassert", v, 16'h0020);
    @(negedge clk); pcieDeassertMsg = 1'b1;
    @(negedge clk); pcieDeassertMsg = 1'b0;
    wrReg(1'b0, 16'h0020, 2'b01);
    rdReg(1'b0, v); chk("R10 clear after deassert", v, 16'h0000);
    @(negedge clk); pcieAssertMsg = 1'b1;
    @(negedge clk); pcieAssertMsg = 1'b0;
    wrReg(1'b0, 16'h0020, 2'b01);
    rdReg(1'b0, v); chk("R10 new assert re-arms hold", v, 16'h0020);
    @(negedge clk); pcieDeassertMsg = 1'b1;
    @(negedge clk); pcieDeassertMsg = 1'b0;
    wrReg(1'b0, 16'h0020, 2'b01);
  endtask

  task automatic testResume();
    logic [15:0] v;
    @(negedge clk); usbWakeReq = 1'b1; intDevPme = 4'b0001;
    @(negedge clk); usbWakeReq = 1'b0; intDevPme = 4'b0000;
    @(negedge clk); resumeRst = 1'b1;
    @(negedge clk); resumeRst = 1'b0;
    rdReg(1'b0, v); chk("R11 resume reset clears usb only", v, 16'h0001);
    wrReg(1'b0, 16'h0001, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    waitCyc(3);
    testReset();
    rst_n = 1'b1;
    waitCyc(2);
    testReset();
    testSourcesAndClear();
    testPins();
    testEnable();
    testRouting();
    testWake();
    testHwWins();
    testPcie();
    testResume();
    waitCyc(2);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule